// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution stage of a 32-bit datapath. Each accepted operation takes a first operand, a second operand that an upstream shifter has already shifted, and that shifter's carry-out. It performs one of five add/subtract forms or one of six bitwise forms. A four-bit condition register holds negative, zero, carry and overflow, and it keeps its value from one operation to the next. The operation may write it when asked to, and the four compare/test forms always write it.

An operation is presented with `op_valid` high for one cycle. The result and the flags are registered at that clock edge. A small output state machine marks what the previous cycle produced. In state ST_IDLE nothing completed. In state ST_RESULT a result was written and `result_valid` is high. In state ST_FLAGS a compare/test form changed only the flags. The state moves on every clock. It goes to ST_RESULT when a valid result-writing operation is accepted, to ST_FLAGS when a valid compare/test operation is accepted, and to ST_IDLE in every other case. Reset forces ST_IDLE.

Top module: `alu_flag_unit`

## Requirements
- R1: Out of reset, `flags` is 4'b0000, `result` is 0 and `result_valid` is 0. `flags` is packed {N,Z,C,V} from bit 3 down to bit 0.
- R2: The arithmetic codes compute the following: 0 gives A+B, 1 gives A+B+C, 2 gives A-B, 3 gives A-B+C-1, and 4 gives B-A. Here C is the stored carry flag. The result is modulo 2^32.
- R3: The bitwise codes compute the following: 5 gives A&B, 6 gives A|B, 7 gives A^B, 8 gives A|~B, 9 gives A&~B, and 10 gives ~B.
- R4: For codes 0 to 10 with `set_flags` low, all four flags keep their previous values.
- R5: For arithmetic with flags written, N is result bit 31 and Z is set when the result is zero. C is the carry out of the adder, with subtraction formed as A+~B+1 so that C=1 means no borrow. V is the signed overflow. For example, 0xFFFFFFFF+1 gives result 0 and flags 4'b0110.
- R6: For bitwise codes with flags written, N and Z come from the result, C takes `shift_carry`, and V keeps its value.
- R7: The compare/test codes always write the flags, whatever `set_flags` is. Code 11 uses the subtract rules, 12 uses the add rules, 13 uses the AND rules and 14 uses the XOR rules. They do not assert `result_valid` and they leave `result` unchanged.
- R8: For codes 0 to 10, `result_valid` is high in exactly the cycle after `op_valid`, with the new `result`. While `result_valid` is low, `result` does not change.
- R9: Code 15 with `op_valid` changes neither `flags` nor `result` and does not assert `result_valid`.
- R10: The carry-using codes 1 and 3 read the carry as registered before their own edge. Two operations in back-to-back cycles therefore chain through the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see R2, R3, R7, R9) |
| set_flags | input | 1 | Request flag write for codes 0 to 10 |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Carry-out of the upstream shifter |
| result | output | 32 | Registered result |
| result_valid | output | 1 | Result written in the previous cycle |
| flags | output | 4 | {N,Z,C,V} |

## Verification
Both `result` and `flags` are due one clock after the cycle in which `op_valid` is high, and `result_valid` is high for that one following cycle. The bench drives inputs on the falling edge and holds `op_valid` for a single cycle. It checks on the next falling edge, which comes half a period after the capturing rising edge. In the back-to-back test, the first operation's outputs are checked on the same falling edge at which the second operation is driven, and the second one's outputs are checked a cycle later.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_RSB = 4'd4,
        OP_AND = 4'd5,
        OP_ORR = 4'd6,
        OP_EOR = 4'd7,
        OP_ORN = 4'd8,
        OP_BIC = 4'd9,
        OP_MVN = 4'd10,
        OP_CMP = 4'd11,
        OP_CMN = 4'd12,
        OP_TST = 4'd13,
        OP_TEQ = 4'd14,
        OP_NOP = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FLAGS  = 2'd2
    } out_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           carry_flag,
    output logic [W-1:0]   sum,
    output logic           c_out,
    output logic           v_out
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         cin;
    logic [W:0]   wide;

    // Every form reduces to x + y + cin on one adder
    always_comb begin
        x   = a;
        y   = b;
        cin = 1'b0;
        unique case (op)
            OP_ADD: begin x = a;  y = b;  cin = 1'b0;       end
            OP_ADC: begin x = a;  y = b;  cin = carry_flag; end
            OP_SUB: begin x = a;  y = ~b; cin = 1'b1;       end
            OP_SBC: begin x = a;  y = ~b; cin = carry_flag; end
            OP_RSB: begin x = ~a; y = b;  cin = 1'b1;       end
            default: begin x = a; y = b;  cin = 1'b0;       end
        endcase
    end

    assign wide  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign sum   = wide[W-1:0];
    assign c_out = wide[W];
    assign v_out = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    // One bit cell per lane, replicated across the word
    for (genvar g = 0; g < W; g++) begin : g_bit
        always_comb begin
            unique case (op)
                OP_AND:  res[g] = a[g] & b[g];
                OP_ORR:  res[g] = a[g] | b[g];
                OP_EOR:  res[g] = a[g] ^ b[g];
                OP_ORN:  res[g] = a[g] | ~b[g];
                OP_BIC:  res[g] = a[g] & ~b[g];
                OP_MVN:  res[g] = ~b[g];
                default: res[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           arith_src,
    input  logic [W-1:0]   res,
    input  logic           adder_c,
    input  logic           adder_v,
    input  logic           shift_c,
    output flags_t         flags_q
);
    flags_t flags_d;

    always_comb begin
        flags_d.n = res[W-1];
        flags_d.z = ~|res;
        flags_d.c = arith_src ? adder_c : shift_c;
        flags_d.v = arith_src ? adder_v : flags_q.v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (wr_en) begin
            flags_q <= flags_d;
        end
    end

    // R4: without a write request, the register keeps its value
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flags_q));
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [3:0]     op_code,
    input  logic           set_flags,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic           shift_carry,
    output logic [W-1:0]   result,
    output logic           result_valid,
    output logic [3:0]     flags
);
    alu_op_e    op;
    alu_op_e    arith_op;
    alu_op_e    logic_op;
    out_state_e state_q;
    out_state_e state_d;
    flags_t     flags_q;

    logic         is_arith;
    logic         is_compare;
    logic         writes_res;
    logic         flag_wr;
    logic [W-1:0] sum;
    logic [W-1:0] bitres;
    logic [W-1:0] value;
    logic         add_c;
    logic         add_v;
    logic [W-1:0] result_q;

    assign op = alu_op_e'(op_code);

    // Decode: fold compare/test forms onto their computing forms
    always_comb begin
        arith_op   = OP_ADD;
        logic_op   = OP_AND;
        is_arith   = 1'b0;
        is_compare = 1'b0;
        writes_res = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB: begin
                arith_op   = op;
                is_arith   = 1'b1;
                writes_res = 1'b1;
            end
            OP_AND, OP_ORR, OP_EOR, OP_ORN, OP_BIC, OP_MVN: begin
                logic_op   = op;
                writes_res = 1'b1;
            end
            OP_CMP: begin arith_op = OP_SUB; is_arith = 1'b1; is_compare = 1'b1; end
            OP_CMN: begin arith_op = OP_ADD; is_arith = 1'b1; is_compare = 1'b1; end
            OP_TST: begin logic_op = OP_AND; is_compare = 1'b1; end
            OP_TEQ: begin logic_op = OP_EOR; is_compare = 1'b1; end
            default: begin end
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .op         (arith_op),
        .a          (opnd_a),
        .b          (opnd_b),
        .carry_flag (flags_q.c),
        .sum        (sum),
        .c_out      (add_c),
        .v_out      (add_v)
    );

    alu_logic #(.W(W)) u_logic (
        .op  (logic_op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (bitres)
    );

    assign value   = is_arith ? sum : bitres;
    assign flag_wr = op_valid && ((writes_res && set_flags) || is_compare);

    alu_flags #(.W(W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (flag_wr),
        .arith_src (is_arith),
        .res       (value),
        .adder_c   (add_c),
        .adder_v   (add_v),
        .shift_c   (shift_carry),
        .flags_q   (flags_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (op_valid && writes_res) begin
            result_q <= value;
        end
    end

    // Output state machine: next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FLAGS: begin
                if (op_valid && writes_res)      state_d = ST_RESULT;
                else if (op_valid && is_compare) state_d = ST_FLAGS;
                else                             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output state machine: outputs
    always_comb begin
        result_valid = 1'b0;
        unique case (state_q)
            ST_RESULT: result_valid = 1'b1;
            ST_IDLE, ST_FLAGS: result_valid = 1'b0;
            default: result_valid = 1'b0;
        endcase
    end

    assign result = result_q;
    assign flags  = flags_q;

    // R8: a result-writing code yields a valid result next cycle
    p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 4'd10) |=> result_valid);

    // R8: the result register moves only when a valid result is shown
    p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    // R7: compare/test and reserved codes never raise result_valid
    p_noval_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd11) |=> !result_valid);

    // R6: bitwise forms keep the overflow flag
    p_logic_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && set_flags && op_code >= 4'd5 && op_code <= 4'd10)
        |=> (flags[0] == $past(flags[0])));

    // R9: the reserved code touches nothing
    p_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd15) |=> $stable(flags));
endmodule

// File: tb/alu_flag_unit_tb_top.sv
`timescale 1ns/1ps
module alu_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        set_flags = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        shift_carry = 1'b0;
    logic [31:0] result;
    logic        result_valid;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .set_flags(set_flags), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shift_carry(shift_carry), .result(result),
        .result_valid(result_valid), .flags(flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic sf, input logic [31:0] a,
                         input logic [31:0] b, input logic sc);
        op_valid = 1'b1; op_code = c; set_flags = sf;
        opnd_a = a; opnd_b = b; shift_carry = sc;
    endtask

    // One operation, checked half a cycle after its capturing edge
    task automatic op_res(input string tag, input logic [3:0] c, input logic sf,
                          input logic [31:0] a, input logic [31:0] b, input logic sc,
                          input logic [31:0] exp_res, input logic [3:0] exp_fl);
        @(negedge clk); drive(c, sf, a, b, sc);
        @(negedge clk); op_valid = 1'b0;
        chk({tag, " result"}, result, exp_res);
        chk({tag, " valid"}, {31'd0, result_valid}, 32'd1);
        chk({tag, " flags"}, {28'd0, flags}, {28'd0, exp_fl});
    endtask

    task automatic op_nores(input string tag, input logic [3:0] c, input logic sf,
                            input logic [31:0] a, input logic [31:0] b, input logic sc,
                            input logic [3:0] exp_fl);
        logic [31:0] prev;
        prev = result;
        @(negedge clk); drive(c, sf, a, b, sc);
        @(negedge clk); op_valid = 1'b0;
        chk({tag, " result held"}, result, prev);
        chk({tag, " valid low"}, {31'd0, result_valid}, 32'd0);
        chk({tag, " flags"}, {28'd0, flags}, {28'd0, exp_fl});
    endtask

    task automatic t_reset;
        chk("R1 flags", {28'd0, flags}, 32'd0);
        chk("R1 result", result, 32'd0);
        chk("R1 valid", {31'd0, result_valid}, 32'd0);
    endtask

    task automatic t_add;
        op_res("R5 add wrap", 4'd0, 1, 32'hFFFFFFFF, 32'h1, 0, 32'h0, 4'b0110);
        op_res("R5 add carry from adder", 4'd0, 1, 32'h1, 32'hFFFFFE00, 1, 32'hFFFFFE01, 4'b1000);
        op_res("R5 add overflow", 4'd0, 1, 32'h7FFFFFFF, 32'h1, 0, 32'h80000000, 4'b1001);
        op_res("R4 add no flag write", 4'd0, 0, 32'h2, 32'h3, 0, 32'h5, 4'b1001);
        // R8: idle cycle drops result_valid
        @(negedge clk);
        chk("R8 valid single pulse", {31'd0, result_valid}, 32'd0);
    endtask

    task automatic t_sub;
        op_res("R5 sub equal", 4'd2, 1, 32'h5, 32'h5, 0, 32'h0, 4'b0110);
        op_res("R5 sub borrow", 4'd2, 1, 32'h3, 32'h5, 0, 32'hFFFFFFFE, 4'b1000);
        op_res("R5 sub overflow", 4'd2, 1, 32'h80000000, 32'h1, 0, 32'h7FFFFFFF, 4'b0011);
    endtask

    task automatic t_carry;
        op_res("R2 adc c1", 4'd1, 0, 32'h5, 32'h7, 0, 32'hD, 4'b0011);
        op_res("R2 sbc c1", 4'd3, 0, 32'hA, 32'h3, 0, 32'h7, 4'b0011);
        op_res("R2 add clears c", 4'd0, 1, 32'h1, 32'h1, 0, 32'h2, 4'b0000);
        op_res("R2 adc c0", 4'd1, 0, 32'h5, 32'h7, 0, 32'hC, 4'b0000);
        op_res("R2 sbc c0", 4'd3, 0, 32'hA, 32'h3, 0, 32'h6, 4'b0000);
        op_res("R2 rsb", 4'd4, 1, 32'h3, 32'hA, 0, 32'h7, 4'b0010);
    endtask

    task automatic t_chain;
        @(negedge clk); drive(4'd0, 1, 32'hFFFFFFFF, 32'h1, 0);
        @(negedge clk);
        chk("R10 first result", result, 32'h0);
        chk("R10 first flags", {28'd0, flags}, 32'h6);
        drive(4'd1, 0, 32'h0, 32'h0, 0);
        @(negedge clk); op_valid = 1'b0;
        chk("R10 chained adc", result, 32'h1);
        chk("R10 valid second", {31'd0, result_valid}, 32'd1);
    endtask

    task automatic t_logic;
        op_res("R5 set v", 4'd0, 1, 32'h7FFFFFFF, 32'h1, 0, 32'h80000000, 4'b1001);
        op_res("R6 and", 4'd5, 1, 32'hF0F0F0F0, 32'h0F0F0F0F, 1, 32'h0, 4'b0111);
        op_res("R6 eor", 4'd7, 1, 32'hFFFFFFFF, 32'h0000FFFF, 0, 32'hFFFF0000, 4'b1001);
        op_res("R3 orn", 4'd8, 0, 32'h0, 32'hFFFF0000, 1, 32'h0000FFFF, 4'b1001);
        op_res("R3 bic", 4'd9, 0, 32'hFFFFFFFF, 32'h0000000F, 0, 32'hFFFFFFF0, 4'b1001);
        op_res("R6 mvn", 4'd10, 1, 32'h12345678, 32'hFFFFFFFF, 0, 32'h0, 4'b0101);
        op_res("R3 mvn value", 4'd10, 0, 32'h0, 32'h12345678, 0, 32'hEDCBA987, 4'b0101);
        op_res("R3 orr", 4'd6, 0, 32'h0F, 32'hF0, 0, 32'hFF, 4'b0101);
    endtask

    task automatic t_compare;
        op_nores("R7 cmp equal", 4'd11, 0, 32'h5, 32'h5, 0, 4'b0110);
        op_nores("R7 cmn", 4'd12, 0, 32'hFFFFFFFF, 32'h1, 0, 4'b0110);
        op_nores("R7 cmp less", 4'd11, 0, 32'h0, 32'h1, 0, 4'b1000);
        op_nores("R7 tst", 4'd13, 0, 32'h80000000, 32'h80000000, 1, 4'b1010);
        op_nores("R7 teq", 4'd14, 1, 32'h5, 32'h5, 0, 4'b0100);
    endtask

    task automatic t_reserved;
        op_nores("R9 reserved", 4'd15, 1, 32'h0, 32'h0, 1, 4'b0100);
        chk("R9 result untouched", result, 32'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_carry();
        t_chain();
        t_logic();
        t_compare();
        t_reserved();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule